// File: doc/BRIEF.md
# ADC Sequence Start Controller

This block decides when a converter's sequencer begins a conversion sequence. A start can come from a software strobe or from an external trigger pin. The pin is synchronized inside the block and can be read as an edge or as a level, with either polarity. The block drives a single-cycle start pulse towards the sequencer. It learns when the sequencer is busy and when it has finished through a busy level and a done pulse.

Four control bits select the behaviour: trigger enable, level/edge select, polarity and scan. With the trigger disabled, software starts either one sequence or an endless chain of sequences. With the trigger enabled, only the pin can start work. In edge mode, each qualifying edge that arrives while the sequencer is idle yields exactly one sequence. An edge that arrives while a sequence runs sets a sticky overrun flag, which a clear strobe resets. In level mode, sequences follow one another for as long as the pin stays at its active level. Pulsing the control-write strobe while a sequence is running ends any continuous operation.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, start_o and ovr_o are both 0.
- R2: With trig_en_i=0 and scan_i=0, a sw_start_i pulse while idle gives exactly one start_o pulse, in the cycle after the strobe is sampled, and no further start after the done pulse. With the trigger disabled, the trigger pin never starts a sequence.
- R3: With trig_en_i=0 and scan_i=1, a sw_start_i pulse starts a chain of sequences. Each new start_o comes in the cycle after seq_done_i is sampled.
- R4: With trig_en_i=1 and level_mode_i=0, polarity_i=1 selects rising edges and polarity_i=0 selects falling edges. Each qualifying edge seen while idle gives exactly one start_o, whatever scan_i is. The opposite edge gives none.
- R5: With trig_en_i=1 and level_mode_i=1, polarity_i=1 means active high and polarity_i=0 means active low. While the pin stays active, a new start_o follows in the cycle after each seq_done_i. When the pin is inactive at done, no start follows.
- R6: While trig_en_i=1, sw_start_i has no effect on start_o.
- R7: In edge mode, a qualifying edge detected while a sequence is in progress sets ovr_o and starts nothing. ovr_o stays set until a clear.
- R8: In level mode, the pin going inactive and then active again during a sequence does not set ovr_o.
- R9: ovr_clr_i clears ovr_o on the next cycle. If an overrun is detected in the same cycle as a clear, ovr_o is set.
- R10: A ctrl_wr_i pulse while a sequence is in progress ends scan and level chaining: no start_o follows that sequence's done without a new software start or trigger edge.
- R11: A change on trig_i that is held long enough produces start_o exactly SYNC_STAGES+1 cycles after the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_en_i | input | 1 | Start sequences from the pin instead of software |
| level_mode_i | input | 1 | 1: level-sensitive trigger, 0: edge-sensitive |
| polarity_i | input | 1 | 1: rising edge / active high, 0: falling edge / active low |
| scan_i | input | 1 | Software continuous mode |
| ctrl_wr_i | input | 1 | Strobe that comes with any control-bit write |
| trig_i | input | 1 | Raw external trigger pin |
| sw_start_i | input | 1 | Software start strobe |
| seq_busy_i | input | 1 | Sequencer busy level |
| seq_done_i | input | 1 | Sequencer end-of-sequence pulse |
| ovr_clr_i | input | 1 | Overrun clear strobe |
| start_o | output | 1 | Single-cycle sequence start |
| ovr_o | output | 1 | Sticky trigger overrun flag |

## Verification
The start path is tried with single software strobes, software chains, rising and falling pin pulses under both polarity settings, and held or dropped levels. These patterns separate the once, scan, edge and level decoding, and they show that the wrong edge is rejected. Timed gaps between starts show that a restart follows done without delay, and one directed pulse pins the synchronizer latency. Overlapping edges, level dips inside a sequence and a clear that coincides with a new overrun separate sticky setting, the level exemption and the set-over-clear priority. Random software strobes with the trigger enabled, random pin noise with it disabled, and random well-spaced pulses check that the unused source is ignored and that each pulse yields one start.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;

  typedef enum logic [1:0] {
    MODE_SW_ONCE = 2'd0,
    MODE_SW_SCAN = 2'd1,
    MODE_EDGE    = 2'd2,
    MODE_LEVEL   = 2'd3
  } trig_mode_e;

  function automatic trig_mode_e decode_mode(input logic trig_en, input logic level,
                                             input logic scan);
    if (!trig_en) return scan ? MODE_SW_SCAN : MODE_SW_ONCE;
    return level ? MODE_LEVEL : MODE_EDGE;
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
`timescale 1ns/1ps
module adc_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign q_o = sync_q[LAST];
endmodule

// File: rtl/adc_trig_detect.sv
`timescale 1ns/1ps
module adc_trig_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic polarity_i,
  output logic act_o,
  output logic edge_o
);
  logic act_prev_q;

  // normalise to active-high so that one detector serves both polarities
  assign act_o  = polarity_i ? sync_i : ~sync_i;
  assign edge_o = act_o & ~act_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_prev_q <= 1'b0;
    else         act_prev_q <= act_o;
  end
endmodule

// File: rtl/adc_trig_fsm.sv
`timescale 1ns/1ps
module adc_trig_fsm
  import adc_trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_en_i,
  input  logic level_mode_i,
  input  logic scan_i,
  input  logic ctrl_wr_i,
  input  logic act_i,
  input  logic edge_i,
  input  logic sw_start_i,
  input  logic seq_busy_i,
  input  logic seq_done_i,
  input  logic ovr_clr_i,
  output logic start_o,
  output logic ovr_o,
  output logic seq_act_o
);
  trig_mode_e mode;
  logic busy_eff, abort, sw_go;
  logic start_req, ovr_set;
  logic seq_act_q, cont_q, hold_q, start_q, ovr_q;

  assign mode     = decode_mode(trig_en_i, level_mode_i, scan_i);
  // the done cycle counts as idle so that a restart costs no extra cycle
  assign busy_eff = (seq_act_q | seq_busy_i) & ~seq_done_i;
  assign abort    = ctrl_wr_i & seq_act_q;
  assign sw_go    = sw_start_i & ~busy_eff;

  always_comb begin
    start_req = 1'b0;
    ovr_set   = 1'b0;
    unique case (mode)
      MODE_SW_ONCE: start_req = sw_go;
      MODE_SW_SCAN: start_req = sw_go | (cont_q & seq_done_i);
      MODE_EDGE: begin
        start_req = edge_i & ~busy_eff;
        ovr_set   = edge_i & busy_eff;
      end
      MODE_LEVEL:   start_req = act_i & ~busy_eff & (~hold_q | edge_i);
      default:      start_req = 1'b0;
    endcase
    if (abort) start_req = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_act_q <= 1'b0;
      cont_q    <= 1'b0;
      hold_q    <= 1'b0;
      start_q   <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      start_q <= start_req;

      if (start_req)       seq_act_q <= 1'b1;
      else if (seq_done_i) seq_act_q <= 1'b0;

      if (abort || mode != MODE_SW_SCAN) cont_q <= 1'b0;
      else if (sw_go)                    cont_q <= 1'b1;

      if (abort)                                    hold_q <= 1'b1;
      else if (edge_i || (sw_start_i && !trig_en_i)) hold_q <= 1'b0;

      if (ovr_set)        ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign start_o   = start_q;
  assign ovr_o     = ovr_q;
  assign seq_act_o = seq_act_q;
endmodule

// File: rtl/adc_trig_ctrl.sv
`timescale 1ns/1ps
module adc_trig_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_en_i,
  input  logic level_mode_i,
  input  logic polarity_i,
  input  logic scan_i,
  input  logic ctrl_wr_i,
  input  logic trig_i,
  input  logic sw_start_i,
  input  logic seq_busy_i,
  input  logic seq_done_i,
  input  logic ovr_clr_i,
  output logic start_o,
  output logic ovr_o
);
  logic trig_sync, trig_act, trig_edge, seq_act;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_i),
    .q_o   (trig_sync)
  );

  adc_trig_detect i_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (trig_sync),
    .polarity_i(polarity_i),
    .act_o     (trig_act),
    .edge_o    (trig_edge)
  );

  adc_trig_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_en_i   (trig_en_i),
    .level_mode_i(level_mode_i),
    .scan_i      (scan_i),
    .ctrl_wr_i   (ctrl_wr_i),
    .act_i       (trig_act),
    .edge_i      (trig_edge),
    .sw_start_i  (sw_start_i),
    .seq_busy_i  (seq_busy_i),
    .seq_done_i  (seq_done_i),
    .ovr_clr_i   (ovr_clr_i),
    .start_o     (start_o),
    .ovr_o       (ovr_o),
    .seq_act_o   (seq_act)
  );
endmodule

// File: rtl/adc_trig_chk.sv
`timescale 1ns/1ps
module adc_trig_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic trig_en_i,
  input logic level_mode_i,
  input logic ctrl_wr_i,
  input logic ovr_clr_i,
  input logic start_o,
  input logic ovr_o,
  input logic seq_act_i
);
  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  assert_ovr_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_o) |-> $past(ovr_clr_i));

  assert_ovr_edge_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(trig_en_i && !level_mode_i));

  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && seq_act_i) |=> !start_o);
endmodule

bind adc_trig_ctrl adc_trig_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_en_i   (trig_en_i),
  .level_mode_i(level_mode_i),
  .ctrl_wr_i   (ctrl_wr_i),
  .ovr_clr_i   (ovr_clr_i),
  .start_o     (start_o),
  .ovr_o       (ovr_o),
  .seq_act_i   (seq_act)
);

// File: tb/test_adc_trig_ctrl.sv
`timescale 1ns/1ps
module test_adc_trig_ctrl;
  localparam int SYNC    = 2;
  localparam int SEQ_LEN = 12;
  localparam int GAP     = SEQ_LEN + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic trig_en_i = 0, level_mode_i = 0, polarity_i = 1, scan_i = 0, ctrl_wr_i = 0;
  logic trig_i = 0, sw_start_i = 0, seq_busy_i = 0, seq_done_i = 0, ovr_clr_i = 0;
  logic start_o, ovr_o;

  int n_run = 0, n_fail = 0, cyc = 0, cnt = 0;
  int n_start = 0, last_start = 0, gap = 0;
  bit new_start = 0, ovr_seen = 0;

  always #5 clk_i = ~clk_i;

  adc_trig_ctrl #(.SYNC_STAGES(SYNC)) i_adc_trig_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sample after the edge, then model the sequencer for the next cycle
  task automatic tick();
    @(posedge clk_i); #1;
    cyc++;
    new_start = start_o;
    if (start_o) begin n_start++; gap = cyc - last_start; last_start = cyc; end
    if (ovr_o) ovr_seen = 1;
    seq_done_i = 0;
    if (start_o) cnt = SEQ_LEN;
    else if (cnt > 0) begin cnt--; if (cnt == 0) seq_done_i = 1; end
    seq_busy_i = (cnt > 0) || seq_done_i;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // starts expected from n well-spaced qualifying pulses
  function automatic int exp_pulse_starts(input int n);
    return n;
  endfunction

  function automatic int exp_ignored_starts(input int n);
    return 0 * n;
  endfunction

  task automatic setup_edge(input bit pol);
    trig_en_i = 0; level_mode_i = 0; polarity_i = pol; trig_i = ~pol;
    run(6);
    trig_en_i = 1;
    run(2);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int s0, k, w, np;
    s0 = $urandom(32'd4242);
    #12; chk(start_o == 0 && ovr_o == 0, "R1 reset", {start_o, ovr_o}, 0);
    rst_ni = 1;
    run(3);
    chk(start_o == 0 && ovr_o == 0, "R1 after reset", {start_o, ovr_o}, 0);

    // R2 single software sequence
    n_start = 0; sw_start_i = 1; tick(); sw_start_i = 0;
    chk(start_o == 1, "R2 start latency", start_o, 1);
    run(40);
    chk(n_start == 1, "R2 one sequence", n_start, 1);

    // R3 scan chain, then R10 abort
    scan_i = 1; n_start = 0; sw_start_i = 1; tick(); sw_start_i = 0;
    k = 0;
    while (n_start < 3) begin tick(); k++; if (k > 100) break; end
    chk(n_start == 3 && gap == GAP, "R3 back-to-back gap", gap, GAP);
    ctrl_wr_i = 1; tick(); ctrl_wr_i = 0;
    n_start = 0; run(50);
    chk(n_start == 0, "R10 abort chain", n_start, 0);

    // R6 software strobes ignored with trigger enabled (random)
    setup_edge(1); n_start = 0; np = 0;
    for (int i = 0; i < 150; i++) begin
      sw_start_i = ($urandom % 4) == 0; if (sw_start_i) np++; tick();
    end
    sw_start_i = 0; run(20);
    chk(n_start == exp_ignored_starts(np), "R6 sw start ignored", n_start, 0);

    // R4 + R11 rising edge with scan set
    n_start = 0; trig_i = 1;
    tick(); chk(start_o == 0, "R11 no early start", start_o, 0);
    tick(); chk(start_o == 0, "R11 no early start", start_o, 0);
    tick(); chk(start_o == 1, "R11 latency SYNC+1", start_o, 1);
    run(30);
    chk(n_start == 1, "R4 one start per rising edge", n_start, 1);
    n_start = 0; trig_i = 0; run(30);
    chk(n_start == 0, "R4 falling ignored when rising selected", n_start, 0);
    setup_edge(0); n_start = 0; trig_i = 0; run(30);
    chk(n_start == 1, "R4 falling edge start", n_start, 1);
    n_start = 0; trig_i = 1; run(30);
    chk(n_start == 0, "R4 rising ignored when falling selected", n_start, 0);

    // R7 overrun from an edge inside a sequence
    setup_edge(1); n_start = 0;
    trig_i = 1; run(4); trig_i = 0; run(3); trig_i = 1; run(4);
    chk(ovr_o == 1, "R7 overrun set", ovr_o, 1);
    run(30);
    chk(ovr_o == 1, "R7 overrun sticky", ovr_o, 1);
    chk(n_start == 1, "R7 no start from overlapping edge", n_start, 1);

    // R9 clear, then clear colliding with a new overrun
    ovr_clr_i = 1; tick(); ovr_clr_i = 0; tick();
    chk(ovr_o == 0, "R9 clear", ovr_o, 0);
    trig_i = 0; run(4); trig_i = 1; run(4); trig_i = 0; run(3);
    ovr_clr_i = 1; ovr_seen = 0; trig_i = 1; run(6);
    chk(ovr_seen == 1, "R9 set wins over clear", ovr_seen, 1);
    tick();
    chk(ovr_o == 0, "R9 clear held", ovr_o, 0);
    ovr_clr_i = 0; run(30);

    // R5 level chaining, active high
    trig_en_i = 0; level_mode_i = 1; polarity_i = 1; trig_i = 0; run(6);
    trig_en_i = 1; n_start = 0; trig_i = 1;
    k = 0;
    while (n_start < 3) begin tick(); k++; if (k > 100) break; end
    chk(n_start == 3 && gap == GAP, "R5 level restart gap", gap, GAP);
    // R8 dip inside a sequence
    trig_i = 0; run(3); trig_i = 1; ovr_seen = 0; run(30);
    chk(ovr_seen == 0, "R8 level dip no overrun", ovr_seen, 0);
    while (!new_start) tick();
    trig_i = 0; n_start = 0; run(40);
    chk(n_start == 0, "R5 inactive at done stops", n_start, 0);
    // R5 active low
    trig_en_i = 0; polarity_i = 0; trig_i = 1; run(6);
    trig_en_i = 1; n_start = 0; trig_i = 0; run(3 + 2 * GAP);
    chk(n_start == 3, "R5 active low chaining", n_start, 3);
    trig_i = 1; run(40);

    // R2 pin ignored with trigger disabled (random noise)
    trig_en_i = 0; scan_i = 0; n_start = 0; ovr_seen = 0;
    for (int i = 0; i < 200; i++) begin trig_i = $urandom % 2; tick(); end
    chk(n_start == 0 && ovr_seen == 0, "R2 pin ignored when disabled", n_start, 0);

    // R4 random spaced pulses, both polarities
    for (int r = 0; r < 4; r++) begin
      setup_edge(r % 2); n_start = 0; ovr_seen = 0;
      np = 3 + $urandom % 4;
      for (int p = 0; p < np; p++) begin
        w = 3 + $urandom % 6;
        trig_i = r % 2; run(w);
        trig_i = ~(r % 2); run(SEQ_LEN + 8 + $urandom % 5);
      end
      run(20);
      chk(n_start == exp_pulse_starts(np) && !ovr_seen, "R4 random pulses", n_start, np);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule